// File: doc/BRIEF.md
# Vector element step sequencer

This block walks one prefixed vector instruction through its elements, one element at a time. A 7-bit step index counts from 0 towards the vector length VL. For every step the block presents the effective register numbers of the instruction's operands to the execution side. An operand flagged as a vector gets the step added to its base register number. An operand flagged as scalar keeps its base number. The last operand slot is the implicit condition-register destination. It obeys the same vector/scalar rule and gets no other adjustment.

The step index and VL live in a 32-bit step-state register, which behaves like a sub-PC. Between elements the PC stays on the instruction, and it advances only once the final element completes. When an exception is taken, the step state is copied into a privileged save register in the same cycle that PC and MSR are saved elsewhere. A return copies it back, so execution resumes at the interrupted element. Both registers are reachable as SPRs 704 and 720. The block also raises illegal instruction in two cases: when the prefix is applied to an instruction class that cannot be extended, and when an effective register number would run past the 128-entry register files.

Top module: `vstep_seq`

## Requirements
- R1: After reset the step index is 0. It rises by exactly one on each clock edge where an element is valid, `elem_done` is high and `exc_take` is low. With `elem_done` low it holds its value, and `elem_idx` shows it.
- R2: Operand i occupies `op_base`/`eff_regs` bits [7i+6:7i]. For a used operand of a prefixed instruction, `eff_regs` equals the base plus the step when its `op_isvec` bit is set, and equals the base when the bit is clear. Slot 3 is the condition-register destination and follows the same rule. An unused operand shows 0.
- R3: When the element at step VL-1 completes, `pc_advance` is 1 in that cycle and the step returns to 0 at the next edge. Completion of any earlier element leaves `pc_advance` at 0.
- R4: A prefixed instruction with VL equal to 0 issues no element (`elem_valid`=0) and raises `pc_advance` in the same cycle. The step state is not changed.
- R5: With `exc_take` high, the save register takes the current step state at the edge. Step and VL do not change, and any `elem_done` in that cycle has no effect. With `exc_return` high, step and VL are reloaded from the save register.
- R6: SPR 704 reads as step in bits [6:0] and VL in bits [13:7], with zeros above bit 13. A write stores bits [13:0] and discards the rest. Reset value is 0.
- R7: SPR 720 holds 14 bits in the same layout and reads zero above them. With `spr_priv`=1 it reads and writes normally. With `spr_priv`=0, any read or write of it raises `illegal`, the read returns 0, and the write is dropped.
- R8: `instr_kind` encodes 0 general, 1 setvl, 2 branch, 3 mtmsr, 4 mfmsr, 5 mtspr, 6 mfspr, 7 other non-extendable. A prefixed instruction of kind 1, 2, 3, 4 or 7 raises `illegal`. In that case no element is issued, `pc_advance` stays 0 and the step is unchanged.
- R9: If any used operand's effective number of a prefixed instruction is 128 or more, `illegal` is raised instead of wrapping. No element is issued, `pc_advance` stays 0 and the step holds.
- R10: An instruction without prefix issues a single element with its base registers, whatever its vector flags or kind. `pc_advance` follows its `elem_done`, and the step state is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction sits at the current PC |
| instr_prefixed | input | 1 | The instruction carries the vector prefix |
| instr_kind | input | 3 | Instruction class, encoding in R8 |
| op_base | input | 28 | Base register number of each of the 4 operands |
| op_isvec | input | 4 | Per-operand vector flag |
| op_used | input | 4 | Per-operand presence flag |
| elem_done | input | 1 | The offered element completes this cycle |
| exc_take | input | 1 | An exception is being taken this cycle |
| exc_return | input | 1 | Return from exception this cycle |
| spr_wen | input | 1 | SPR write strobe |
| spr_ren | input | 1 | SPR read strobe |
| spr_addr | input | 10 | SPR number |
| spr_wdata | input | 32 | SPR write data |
| spr_priv | input | 1 | Access is made in privileged state |
| elem_valid | output | 1 | An element is offered for execution |
| elem_idx | output | 7 | Current step index |
| eff_regs | output | 28 | Effective register number of each operand |
| pc_advance | output | 1 | The instruction is finished; the PC may move on |
| illegal | output | 1 | Illegal instruction or privilege fault |
| spr_rdata | output | 32 | SPR read data |

## Verification
The bench targets several corner cases, and for each it knows how a faulty design would show up.
- Exception taken mid-vector: after a handler scribbles over SPR 704 and returns, the next element must be the interrupted one. A design that lets `elem_done` slip through in the exception cycle would skip an element; one that restores from the wrong place would resume at a random step.
- Last element: `pc_advance` must pulse on the last element only, never one early or one late. With VL of zero, the instruction must retire at once without offering an element.
- Overflow: an operand whose effective number would reach 128 must raise `illegal` rather than wrap to a low register. A scalar or unused operand near the top must not trip that check.
- Prefixed non-extendable classes, unprivileged access to the save register, and unprefixed instructions with vector flags set must each leave the step state exactly as it was.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    localparam int REG_W  = 7;
    localparam int SPR_AW = 10;
    localparam int SPR_DW = 32;

    localparam logic [SPR_AW-1:0] SPR_STEP = SPR_AW'(704);
    localparam logic [SPR_AW-1:0] SPR_SAVE = SPR_AW'(720);

    typedef enum logic [2:0] {
        K_GEN    = 3'd0,
        K_SETVL  = 3'd1,
        K_BRANCH = 3'd2,
        K_MTMSR  = 3'd3,
        K_MFMSR  = 3'd4,
        K_MTSPR  = 3'd5,
        K_MFSPR  = 3'd6,
        K_OTHER  = 3'd7
    } kind_e;

    function automatic logic kind_extendable(logic [2:0] k);
        case (kind_e'(k))
            K_GEN, K_MTSPR, K_MFSPR: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/vstep_regcalc.sv
module vstep_regcalc #(
    parameter int REG_W = vstep_pkg::REG_W
) (
    input  logic [REG_W-1:0] base_i,
    input  logic [REG_W-1:0] step_i,
    input  logic             used_i,
    input  logic             vec_i,
    output logic [REG_W-1:0] eff_o,
    output logic             ovf_o
);
    logic [REG_W:0] sum;

    always_comb begin
        sum   = {1'b0, base_i} + (vec_i ? {1'b0, step_i} : '0);
        eff_o = used_i ? sum[REG_W-1:0] : '0;
        ovf_o = used_i & sum[REG_W];
    end
endmodule

// File: rtl/vstep_legal.sv
module vstep_legal #(
    parameter int NUM_OPS = 4
) (
    input  logic               valid_i,
    input  logic               prefixed_i,
    input  logic [2:0]         kind_i,
    input  logic [NUM_OPS-1:0] ovf_i,
    output logic               ill_o
);
    always_comb begin
        ill_o = valid_i & prefixed_i &
                (~vstep_pkg::kind_extendable(kind_i) | (|ovf_i));
    end
endmodule

// File: rtl/vstep_sprport.sv
module vstep_sprport #(
    parameter int REG_W  = vstep_pkg::REG_W,
    parameter int SPR_AW = vstep_pkg::SPR_AW,
    parameter int SPR_DW = vstep_pkg::SPR_DW
) (
    input  logic               ren_i,
    input  logic               wen_i,
    input  logic [SPR_AW-1:0]  addr_i,
    input  logic               priv_i,
    input  logic [2*REG_W-1:0] cur_i,
    input  logic [2*REG_W-1:0] save_i,
    output logic [SPR_DW-1:0]  rdata_o,
    output logic               ill_o
);
    logic hit_cur;
    logic hit_save;

    always_comb begin
        hit_cur  = (addr_i == vstep_pkg::SPR_STEP);
        hit_save = (addr_i == vstep_pkg::SPR_SAVE);
        ill_o    = (ren_i | wen_i) & hit_save & ~priv_i;
        rdata_o  = '0;
        if (ren_i && hit_cur) begin
            rdata_o[2*REG_W-1:0] = cur_i;
        end else if (ren_i && hit_save && priv_i) begin
            rdata_o[2*REG_W-1:0] = save_i;
        end
    end
endmodule

// File: rtl/vstep_ctx.sv
module vstep_ctx #(
    parameter int REG_W  = vstep_pkg::REG_W,
    parameter int SPR_AW = vstep_pkg::SPR_AW,
    parameter int SPR_DW = vstep_pkg::SPR_DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               exc_take_i,
    input  logic               exc_return_i,
    input  logic               spr_wen_i,
    input  logic [SPR_AW-1:0]  spr_addr_i,
    input  logic [SPR_DW-1:0]  spr_wdata_i,
    input  logic               spr_priv_i,
    output logic [REG_W-1:0]   step_o,
    output logic [REG_W-1:0]   vl_o,
    output logic [2*REG_W-1:0] save_o,
    output logic               last_o
);
    typedef struct packed {
        logic [REG_W-1:0] vl;
        logic [REG_W-1:0] step;
    } st_t;

    typedef struct packed {
        st_t cur;
        st_t save;
    } regs_t;

    regs_t          r_d, r_q;
    logic           wr_cur, wr_save;
    logic [REG_W:0] nxt;
    logic           unused_hi;

    assign unused_hi = ^spr_wdata_i[SPR_DW-1:2*REG_W];

    always_comb begin
        r_d     = r_q;
        wr_cur  = spr_wen_i && (spr_addr_i == vstep_pkg::SPR_STEP);
        wr_save = spr_wen_i && (spr_addr_i == vstep_pkg::SPR_SAVE) && spr_priv_i;
        nxt     = {1'b0, r_q.cur.step} + (REG_W+1)'(1);
        last_o  = (nxt >= {1'b0, r_q.cur.vl});
        if (exc_take_i) begin
            r_d.save = r_q.cur;
        end else begin
            if (wr_save) begin
                r_d.save = st_t'(spr_wdata_i[2*REG_W-1:0]);
            end
            if (exc_return_i) begin
                r_d.cur = r_q.save;
            end else if (wr_cur) begin
                r_d.cur = st_t'(spr_wdata_i[2*REG_W-1:0]);
            end else if (adv_i) begin
                r_d.cur.step = last_o ? '0 : nxt[REG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign step_o = r_q.cur.step;
    assign vl_o   = r_q.cur.vl;
    assign save_o = r_q.save;

    p_step_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !exc_take_i && !exc_return_i && !wr_cur && !last_o)
        |=> (step_o == REG_W'($past(step_o) + 1'b1)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !exc_take_i && !exc_return_i && !wr_cur && last_o)
        |=> (step_o == '0));

    p_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_i |=> (save_o == $past({vl_o, step_o})));

    p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return_i && !exc_take_i) |=> ({vl_o, step_o} == $past(save_o)));
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq #(
    parameter int NUM_OPS = 4,
    parameter int REG_W   = vstep_pkg::REG_W,
    parameter int SPR_AW  = vstep_pkg::SPR_AW,
    parameter int SPR_DW  = vstep_pkg::SPR_DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic                     instr_prefixed,
    input  logic [2:0]               instr_kind,
    input  logic [NUM_OPS*REG_W-1:0] op_base,
    input  logic [NUM_OPS-1:0]       op_isvec,
    input  logic [NUM_OPS-1:0]       op_used,
    input  logic                     elem_done,
    input  logic                     exc_take,
    input  logic                     exc_return,
    input  logic                     spr_wen,
    input  logic                     spr_ren,
    input  logic [SPR_AW-1:0]        spr_addr,
    input  logic [SPR_DW-1:0]        spr_wdata,
    input  logic                     spr_priv,
    output logic                     elem_valid,
    output logic [REG_W-1:0]         elem_idx,
    output logic [NUM_OPS*REG_W-1:0] eff_regs,
    output logic                     pc_advance,
    output logic                     illegal,
    output logic [SPR_DW-1:0]        spr_rdata
);
    logic [REG_W-1:0]   step_q, vl_q;
    logic [2*REG_W-1:0] save_q;
    logic               last_elem;
    logic [NUM_OPS-1:0] ovf;
    logic               instr_ill, spr_ill;
    logic               vec_mode, vl_zero, done_ok, adv;

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
        vstep_regcalc #(.REG_W(REG_W)) u_calc (
            .base_i (op_base[gi*REG_W +: REG_W]),
            .step_i (step_q),
            .used_i (op_used[gi]),
            .vec_i  (op_isvec[gi] & instr_prefixed),
            .eff_o  (eff_regs[gi*REG_W +: REG_W]),
            .ovf_o  (ovf[gi])
        );
    end

    vstep_legal #(.NUM_OPS(NUM_OPS)) u_legal (
        .valid_i    (instr_valid),
        .prefixed_i (instr_prefixed),
        .kind_i     (instr_kind),
        .ovf_i      (ovf),
        .ill_o      (instr_ill)
    );

    always_comb begin
        vec_mode   = instr_valid & instr_prefixed;
        vl_zero    = (vl_q == '0);
        elem_valid = instr_valid & ~instr_ill & ~(vec_mode & vl_zero);
        done_ok    = elem_valid & elem_done & ~exc_take;
        adv        = done_ok & vec_mode;
        pc_advance = ~exc_take & instr_valid & ~instr_ill &
                     ((vec_mode & vl_zero) | (done_ok & (~vec_mode | last_elem)));
        illegal    = instr_ill | spr_ill;
        elem_idx   = step_q;
    end

    vstep_ctx #(.REG_W(REG_W), .SPR_AW(SPR_AW), .SPR_DW(SPR_DW)) u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_i        (adv),
        .exc_take_i   (exc_take),
        .exc_return_i (exc_return),
        .spr_wen_i    (spr_wen),
        .spr_addr_i   (spr_addr),
        .spr_wdata_i  (spr_wdata),
        .spr_priv_i   (spr_priv),
        .step_o       (step_q),
        .vl_o         (vl_q),
        .save_o       (save_q),
        .last_o       (last_elem)
    );

    vstep_sprport #(.REG_W(REG_W), .SPR_AW(SPR_AW), .SPR_DW(SPR_DW)) u_spr (
        .ren_i   (spr_ren),
        .wen_i   (spr_wen),
        .addr_i  (spr_addr),
        .priv_i  (spr_priv),
        .cur_i   ({vl_q, step_q}),
        .save_i  (save_q),
        .rdata_o (spr_rdata),
        .ill_o   (spr_ill)
    );

    p_ill_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ill |-> (!elem_valid && !pc_advance));

    p_vl0_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_mode && vl_zero && !instr_ill && !exc_take) |-> (pc_advance && !elem_valid));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!elem_done && !exc_return && !spr_wen) |=> (elem_idx == $past(elem_idx)));

    p_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_ren && spr_addr == vstep_pkg::SPR_SAVE && !spr_priv)
        |-> (illegal && spr_rdata == '0));
endmodule

// File: tb/sim_vstep_seq.sv
module sim_vstep_seq;
    localparam int RW = 7;
    localparam int NO = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             instr_valid, instr_prefixed;
    logic [2:0]       instr_kind;
    logic [NO*RW-1:0] op_base;
    logic [NO-1:0]    op_isvec, op_used;
    logic             elem_done, exc_take, exc_return;
    logic             spr_wen, spr_ren, spr_priv;
    logic [9:0]       spr_addr;
    logic [31:0]      spr_wdata;
    logic             elem_valid, pc_advance, illegal;
    logic [RW-1:0]    elem_idx;
    logic [NO*RW-1:0] eff_regs;
    logic [31:0]      spr_rdata;

    vstep_seq u0 (.*);

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int m_step, m_vl, m_save;
    int b_base[NO];
    bit b_vec[NO], b_used[NO];
    bit b_pfx;
    int b_kind;

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int st_val(int vl, int st);
        return ((vl & 127) << 7) | (st & 127);
    endfunction

    function automatic bit kind_bad(int k);
        return !(k == 0 || k == 5 || k == 6);
    endfunction

    function automatic int exp_eff(int i);
        if (!b_used[i]) return 0;
        return b_base[i] + ((b_pfx && b_vec[i]) ? m_step : 0);
    endfunction

    task automatic idle();
        instr_valid = 0; instr_prefixed = 0; instr_kind = 0;
        op_base = '0; op_isvec = '0; op_used = '0;
        elem_done = 0; exc_take = 0; exc_return = 0;
        spr_wen = 0; spr_ren = 0; spr_priv = 0; spr_addr = '0; spr_wdata = '0;
    endtask

    task automatic spr_wr(int addr, logic [31:0] d, bit priv, string req, bit exp_ill);
        spr_wen = 1; spr_addr = 10'(addr); spr_wdata = d; spr_priv = priv;
        #5;
        chk(req, "illegal on SPR write", illegal, exp_ill);
        tick();
        spr_wen = 0; spr_priv = 0;
    endtask

    task automatic spr_rd(string req, int addr, bit priv, int exp, bit exp_ill);
        spr_ren = 1; spr_addr = 10'(addr); spr_priv = priv;
        #5;
        chk(req, "spr_rdata", spr_rdata, exp);
        chk(req, "illegal on SPR read", illegal, exp_ill);
        tick();
        spr_ren = 0; spr_priv = 0;
    endtask

    task automatic elem_cycle(string req, bit done, bit exc, output bit pc_seen);
        bit ovf, e_ill, vl0, e_valid, e_pc;
        for (int i = 0; i < NO; i++) begin
            op_base[i*RW +: RW] = RW'(b_base[i]);
            op_isvec[i] = b_vec[i];
            op_used[i]  = b_used[i];
        end
        instr_prefixed = b_pfx; instr_kind = 3'(b_kind);
        instr_valid = 1; elem_done = done; exc_take = exc;
        #5;
        ovf = 0;
        for (int i = 0; i < NO; i++)
            if (b_used[i] && b_pfx && b_vec[i] && b_base[i] + m_step >= 128) ovf = 1;
        e_ill   = b_pfx && (kind_bad(b_kind) || ovf);
        vl0     = b_pfx && (m_vl == 0);
        e_valid = !e_ill && !vl0;
        e_pc    = !exc && !e_ill && (vl0 || (done && (!b_pfx || m_step + 1 >= m_vl)));
        chk(req, "illegal", illegal, e_ill);
        chk(req, "elem_valid", elem_valid, e_valid);
        chk(req, "pc_advance", pc_advance, e_pc);
        if (e_valid) begin
            for (int i = 0; i < NO; i++)
                chk(req, $sformatf("eff_regs[%0d]", i), eff_regs[i*RW +: RW], exp_eff(i));
            if (b_pfx) chk(req, "elem_idx", elem_idx, m_step);
        end
        pc_seen = e_pc;
        @(posedge clk);
        if (exc) m_save = st_val(m_vl, m_step);
        else if (e_valid && done && b_pfx) m_step = (m_step + 1 >= m_vl) ? 0 : m_step + 1;
        @(negedge clk);
        instr_valid = 0; elem_done = 0; exc_take = 0;
    endtask

    task automatic set_vl(int vl, int st);
        spr_wr(704, 32'(st_val(vl, st)), 0, "R6", 0);
        m_vl = vl; m_step = st;
    endtask

    task automatic random_run(int iters);
        bit pc;
        for (int it = 0; it < iters; it++) begin
            int exc_at, guard;
            bit exc_done;
            set_vl(1 + int'($urandom % 9), 0);
            b_pfx = 1;
            case ($urandom % 3) 0: b_kind = 0; 1: b_kind = 5; default: b_kind = 6; endcase
            for (int i = 0; i < NO; i++) begin
                b_base[i] = int'($urandom % 101);
                b_vec[i]  = 1'($urandom);
                b_used[i] = ($urandom % 4) != 0;
            end
            exc_at = int'($urandom % (m_vl + 3));
            exc_done = 0; pc = 0; guard = 0;
            while (!pc && guard < 60) begin
                guard++;
                if (m_step == exc_at && !exc_done) begin
                    exc_done = 1;
                    elem_cycle("R5", 1, 1, pc);      // elem_done ignored
                    spr_wr(704, $urandom, 0, "R6", 0);
                    spr_rd("R5", 720, 1, m_save, 0);
                    exc_return = 1; tick(); exc_return = 0;
                    m_step = m_save & 127; m_vl = (m_save >> 7) & 127;
                    spr_rd("R5", 704, 0, m_save, 0);
                end else begin
                    // R2 operand mapping, R3 end of vector, R1 stall holds
                    elem_cycle("R2", ($urandom % 5) != 0, 0, pc);
                end
            end
            chk("R3", "instruction retired", pc, 1);
            spr_rd("R3", 704, 0, st_val(m_vl, 0), 0);
        end
    endtask

    initial begin
        bit pc;
        void'($urandom(32'd2024));
        idle();
        rst_n = 0;
        m_step = 0; m_vl = 0; m_save = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R6 reset state and layout
        spr_rd("R6", 704, 0, 0, 0);
        spr_rd("R7", 720, 1, 0, 0);
        #5; chk("R1", "elem_valid idle", elem_valid, 0); chk("R1", "illegal idle", illegal, 0);
        tick();
        spr_wr(704, 32'hFFFF_C000 | 32'(st_val(5, 2)), 0, "R6", 0);
        spr_rd("R6", 704, 0, st_val(5, 2), 0);
        spr_wr(704, 32'hFFFF_FFFF, 0, "R6", 0);
        spr_rd("R6", 704, 0, 32'h3FFF, 0);

        // R7 privilege on save register
        spr_wr(720, 32'h1234, 1, "R7", 0);
        spr_rd("R7", 720, 1, 32'h1234, 0);
        spr_wr(720, 32'h0555, 0, "R7", 1);
        spr_rd("R7", 720, 1, 32'h1234, 0);
        spr_rd("R7", 720, 0, 0, 1);
        spr_wr(720, 32'hFFFF_FFFF, 1, "R7", 0);
        spr_rd("R7", 720, 1, 32'h3FFF, 0);
        m_save = 32'h3FFF;

        // R10 unprefixed: base regs only, state untouched
        set_vl(5, 2);
        b_pfx = 0; b_kind = 1;
        for (int i = 0; i < NO; i++) begin b_base[i] = 10 * i + 3; b_vec[i] = 1; b_used[i] = 1; end
        elem_cycle("R10", 0, 0, pc);
        elem_cycle("R10", 1, 0, pc);
        chk("R10", "pc on done", pc, 1);
        spr_rd("R10", 704, 0, st_val(5, 2), 0);

        // R4 VL zero retires at once
        set_vl(0, 0);
        b_pfx = 1; b_kind = 0;
        elem_cycle("R4", 0, 0, pc);
        chk("R4", "pc with vl 0", pc, 1);
        spr_rd("R4", 704, 0, 0, 0);

        // R9 overflow, scalar and unused near top are fine; CR slot vector
        set_vl(5, 0);
        b_pfx = 1; b_kind = 0;
        b_base[0] = 125; b_vec[0] = 1; b_used[0] = 1;
        b_base[1] = 127; b_vec[1] = 0; b_used[1] = 1;
        b_base[2] = 127; b_vec[2] = 1; b_used[2] = 0;
        b_base[3] = 120; b_vec[3] = 1; b_used[3] = 1;
        for (int s = 0; s < 4; s++) elem_cycle("R9", 1, 0, pc);
        spr_rd("R9", 704, 0, st_val(5, 3), 0);

        // R8 non-extendable classes under prefix
        set_vl(4, 0);
        for (int i = 0; i < NO; i++) begin b_base[i] = i; b_vec[i] = 1; b_used[i] = 1; end
        foreach (b_base[j]) begin end
        b_kind = 1; elem_cycle("R8", 1, 0, pc);
        b_kind = 2; elem_cycle("R8", 1, 0, pc);
        b_kind = 3; elem_cycle("R8", 1, 0, pc);
        b_kind = 4; elem_cycle("R8", 1, 0, pc);
        b_kind = 7; elem_cycle("R8", 1, 0, pc);
        spr_rd("R8", 704, 0, st_val(4, 0), 0);
        b_kind = 5; elem_cycle("R8", 1, 0, pc);
        spr_rd("R8", 704, 0, st_val(4, 1), 0);

        // R1 R2 R3 R5 constrained random
        random_run(40);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule